// File: doc/BRIEF.md
# Serial Transmit Holding Register

This block holds one 24-bit word between a processor (or DMA) write port and a serial output shifter. A write places a word in the holding register and clears the transmit-empty flag. When the shifter is idle, the pending word moves into it and the flag is set again. An interrupt request follows the flag while the interrupt enable is set.

The word-length select decides how many of the upper bytes are sent. 8-bit mode sends bits 23:16, 16-bit mode sends bits 23:8, and 24-bit mode sends the whole word. The most significant bit goes first, one bit for each cycle in which the serial clock enable is high.

Four clear sources return the block to its empty state: hardware reset, software reset, block reset and stop mode. Bus decoding and serial framing are handled elsewhere.

Top module: `stx_top`

## Requirements
- R1: After hardware reset (`rst` high at a clock edge) `tx_empty` is 1, `tx_irq` is 0 and `sdo` is 0.
- R2: A write (`wr_en` high at an edge with no clear source active) makes `tx_empty` 0 from the next cycle.
- R3: `tx_irq` is registered: in each cycle it equals `irq_en AND tx_empty` of the previous cycle, and it is 0 after any clear source.
- R4: The frame length follows `wl_sel`. Code 2'b00 sends 8 bits (word bits 23:16), code 2'b01 sends 16 bits (bits 23:8), and codes 2'b10 and 2'b11 send 24 bits (bits 23:0). Bits are sent MSB first. Each edge with `sclk_en` high moves the next bit onto `sdo`, where it is visible after that edge.
- R5: While the shifter is busy, an edge with `sclk_en` low leaves `sdo` and the bit position unchanged.
- R6: `sw_rst`, `blk_rst` and `stop_mode` each clear the block. A pending word and a frame in flight are both dropped: `tx_empty` becomes 1, `tx_irq` becomes 0, `sdo` becomes 0, and no bit is sent afterwards.
- R7: A pending word moves to the shifter at the first edge at which the shifter is idle, and `tx_empty` becomes 1 at that edge. A transfer happens only when a word is pending. A word written while a frame is in flight waits until that frame ends.
- R8: When a write and a transfer fall on the same edge, the shifter takes the old word, the new word stays pending and `tx_empty` stays 0.
- R9: `wl_sel` is sampled when the word enters the shifter. Changing it mid-frame does not change the length of that frame.
- R10: While the shifter is idle, an edge with `sclk_en` high drives `sdo` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| blk_rst | input | 1 | Block-level reset, synchronous, active high |
| stop_mode | input | 1 | Stop mode; holds the block cleared while high |
| wr_en | input | 1 | Write strobe from the core or DMA |
| wr_data | input | 24 | Word to transmit |
| wl_sel | input | 2 | Word-length select (00: 8, 01: 16, 1x: 24 bits) |
| irq_en | input | 1 | Transmit interrupt enable |
| sclk_en | input | 1 | Serial bit-clock enable, one bit per high cycle |
| sdo | output | 1 | Serial data out, registered |
| tx_empty | output | 1 | Transmit-empty flag, registered |
| tx_irq | output | 1 | Transmit interrupt request, registered |

## Verification
The hardest case to reach is a write that lands on the same edge at which the previous pending word moves into the shifter. To reach it, the bench issues two writes on back-to-back cycles while the shifter is idle. The first word is accepted on the first edge, and the second write coincides with its transfer. The bench then checks that the flag stays clear and that both words leave intact, one after the other. Clearing a pending word also requires a busy shifter. So the bench first stalls a frame by holding `sclk_en` low, then writes a second word before it raises each clear source.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    WL_8   = 2'b00,
    WL_16  = 2'b01,
    WL_24  = 2'b10,
    WL_24X = 2'b11
  } wlen_e;

  // number of serialized bits for a mode, as a multiple of the byte width
  function automatic int unsigned frame_bits(input logic [1:0] sel,
                                             input int unsigned byte_w);
    case (sel)
      WL_8:    frame_bits = byte_w;
      WL_16:   frame_bits = 2 * byte_w;
      default: frame_bits = 3 * byte_w;
    endcase
  endfunction

endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic [W-1:0] hold_data,
  output logic         empty
);

  logic [W-1:0] data_q;
  logic         empty_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_en) begin
      // a write takes precedence over a simultaneous transfer
      data_q  <= wr_data;
      empty_q <= 1'b0;
    end else if (take) begin
      empty_q <= 1'b1;
    end
  end

  assign hold_data = data_q;
  assign empty     = empty_q;

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    wr_en && !clr |=> !empty_q); // R2
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty_q); // R6
  AST_TAKE_SETS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    take && !wr_en && !clr |=> empty_q); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    take && wr_en && !clr |=> !empty_q && hold_data == $past(wr_data)); // R8

endmodule

// File: rtl/stx_shift.sv
module stx_shift #(
  parameter int W    = 24,
  parameter int CW   = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic [CW-1:0] load_len,
  input  logic          sclk_en,
  output logic          sdo,
  output logic          idle
);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          sdo_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (load) begin
      sh_q  <= load_data;
      cnt_q <= load_len;
    end else if (sclk_en) begin
      if (cnt_q != '0) begin
        sdo_q <= sh_q[W-1];
        sh_q  <= {sh_q[W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo  = sdo_q;
  assign idle = (cnt_q == '0);

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> cnt_q == '0); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W)); // R4
  AST_ONE_BIT_PER_EN: assert property (@(posedge clk) disable iff (rst)
    !clr && !load && sclk_en && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !clr && !load && !sclk_en |=> $stable(sdo_q) && $stable(cnt_q)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !clr && !load && sclk_en && cnt_q == '0 |=> !sdo_q); // R10

endmodule

// File: rtl/stx_irq.sv
module stx_irq (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic irq_en,
  input  logic empty,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (clr) irq_q <= 1'b0;
    else     irq_q <= irq_en & empty;
  end

  assign irq = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !clr |=> irq_q == $past(irq_en && empty)); // R3
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq_q); // R6

endmodule

// File: rtl/stx_top.sv
module stx_top #(
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              blk_rst,
  input  logic              stop_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wl_sel,
  input  logic              irq_en,
  input  logic              sclk_en,
  output logic              sdo,
  output logic              tx_empty,
  output logic              tx_irq
);
  import stx_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              clr;
  logic              take;
  logic              sh_idle;
  logic              empty;
  logic [DATA_W-1:0] hold_data;
  logic [CNT_W-1:0]  len;

  assign clr  = rst | sw_rst | blk_rst | stop_mode;
  assign take = !empty && sh_idle;
  assign len  = CNT_W'(frame_bits(wl_sel, BYTE_W));

  stx_hold #(.W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .empty     (empty)
  );

  stx_shift #(.W(DATA_W), .CW(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .load      (take),
    .load_data (hold_data),
    .load_len  (len),
    .sclk_en   (sclk_en),
    .sdo       (sdo),
    .idle      (sh_idle)
  );

  stx_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .irq_en (irq_en),
    .empty  (empty),
    .irq    (tx_irq)
  );

  assign tx_empty = empty;

  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> tx_empty && !tx_irq && !sdo); // R1

endmodule

// File: tb/stx_top_tb.sv
module stx_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst = 1'b0, blk_rst = 1'b0, stop_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [1:0]  wl_sel = 2'b10;
  logic        irq_en = 1'b0;
  logic        sclk_en = 1'b0;
  logic        sdo, tx_empty, tx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stx_top u_dut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .blk_rst(blk_rst),
    .stop_mode(stop_mode), .wr_en(wr_en), .wr_data(wr_data),
    .wl_sel(wl_sel), .irq_en(irq_en), .sclk_en(sclk_en),
    .sdo(sdo), .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  // {mode, word}
  localparam logic [25:0] VEC [8] = '{
    {2'b00, 24'hA51234}, {2'b01, 24'hC3F00F}, {2'b10, 24'h8F0E71},
    {2'b11, 24'h13579B}, {2'b00, 24'h7F00FF}, {2'b01, 24'h0180FE},
    {2'b10, 24'hFFFFFF}, {2'b10, 24'h000001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] m);
    if (m == 2'b00) return 8;
    if (m == 2'b01) return 16;
    return 24;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write one word and collect its frame with sclk_en held high
  task automatic send(input logic [1:0] m, input logic [23:0] d, output logic [23:0] got);
    got = '0;
    wl_sel = m; wr_en = 1'b1; wr_data = d; sclk_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
    check("R2 empty cleared", tx_empty, 0);
    cyc(1);
    check("R7 empty set on transfer", tx_empty, 1);
    for (int i = 0; i < exp_len(m); i++) begin
      cyc(1);
      got = {got[22:0], sdo};
    end
  endtask

  initial begin
    logic [23:0] got, gotb;
    int len, k;
    cyc(3);
    check("R1 empty", tx_empty, 1);
    check("R1 irq", tx_irq, 0);
    check("R1 sdo", sdo, 0);
    rst = 1'b0;
    cyc(2);

    // table-driven frames
    foreach (VEC[i]) begin
      send(VEC[i][25:24], VEC[i][23:0], got);
      len = exp_len(VEC[i][25:24]);
      check("R4 frame bits", got, 32'(VEC[i][23:0] >> (24 - len)));
      cyc(1);
      check("R10 idle sdo", sdo, 0);
    end

    // R9: mode changes mid-frame have no effect
    wl_sel = 2'b00; wr_en = 1'b1; wr_data = 24'hA5FFFF; sclk_en = 1'b1;
    cyc(1); wr_en = 1'b0;
    cyc(1); wl_sel = 2'b10;
    got = '0;
    for (int i = 0; i < 8; i++) begin cyc(1); got = {got[22:0], sdo}; end
    check("R9 bits", got, 32'hA5);
    cyc(1);
    check("R9 frame ended", sdo, 0);

    // R5: stall with sclk_en toggling
    sclk_en = 1'b0; wl_sel = 2'b01; wr_en = 1'b1; wr_data = 24'hB62D00;
    cyc(1); wr_en = 1'b0;
    cyc(1);
    got = '0; k = 0;
    for (int i = 0; i < 40 && k < 16; i++) begin
      logic prev;
      prev = sdo;
      sclk_en = (i % 3) != 0;
      cyc(1);
      if (sclk_en) begin got = {got[22:0], sdo}; k++; end
      else check("R5 sdo held", sdo, prev);
    end
    check("R5 bits", got, 32'hB62D);
    sclk_en = 1'b1; cyc(2);

    // R8: write on the same edge as a transfer
    wl_sel = 2'b10; wr_en = 1'b1; wr_data = 24'h123456;
    cyc(1); wr_data = 24'hFEDCBA;
    cyc(1); wr_en = 1'b0;
    check("R8 empty stays clear", tx_empty, 0);
    got = '0;
    for (int i = 0; i < 24; i++) begin cyc(1); got = {got[22:0], sdo}; end
    check("R8 first word", got, 32'h123456);
    cyc(1);
    check("R7 second transfer", tx_empty, 1);
    gotb = '0;
    for (int i = 0; i < 24; i++) begin cyc(1); gotb = {gotb[22:0], sdo}; end
    check("R8 second word", gotb, 32'hFEDCBA);
    cyc(2);

    // R3: interrupt follows flag
    irq_en = 1'b1; cyc(1);
    check("R3 irq on empty", tx_irq, 1);
    wr_en = 1'b1; wr_data = 24'h0F0F0F; cyc(1); wr_en = 1'b0;
    cyc(1);
    check("R3 irq drops", tx_irq, 0);
    cyc(1);
    check("R3 irq returns", tx_irq, 1);
    irq_en = 1'b0; cyc(1);
    check("R3 irq disabled", tx_irq, 0);
    cyc(30);

    // R6: each secondary clear source drops pending and in-flight words
    for (int s = 0; s < 3; s++) begin
      irq_en = 1'b1; sclk_en = 1'b0; wl_sel = 2'b10;
      wr_en = 1'b1; wr_data = 24'hFFFFFF; cyc(1); wr_en = 1'b0;
      cyc(1);
      wr_en = 1'b1; wr_data = 24'hFFFFFF; cyc(1); wr_en = 1'b0;
      check("R6 pending before clear", tx_empty, 0);
      if (s == 0) sw_rst = 1'b1; else if (s == 1) blk_rst = 1'b1; else stop_mode = 1'b1;
      cyc(1);
      sw_rst = 1'b0; blk_rst = 1'b0; stop_mode = 1'b0; irq_en = 1'b0;
      check("R6 empty after clear", tx_empty, 1);
      check("R6 irq after clear", tx_irq, 0);
      sclk_en = 1'b1;
      k = 0;
      for (int i = 0; i < 50; i++) begin cyc(1); if (sdo) k++; end
      check("R6 no bits after clear", k, 0);
    end

    // R1: hardware reset mid-frame
    wr_en = 1'b1; wr_data = 24'hFFFFFF; cyc(1); wr_en = 1'b0;
    cyc(4); rst = 1'b1; cyc(1); rst = 1'b0;
    check("R1 empty after reset", tx_empty, 1);
    check("R1 sdo after reset", sdo, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule